// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit is the system-control register file and trap sequencer of a simple 32-bit core. Seven control registers are addressed by a 5-bit register number. The core reads them through a combinational read port and writes them through a one-cycle write strobe. The registers are a faulting-address register, a free-running counter, a compare register, a status word, a cause word, the saved exception PC and a read-only configuration word. Eight interrupt request lines are sampled into the cause word every cycle, whether or not they are masked. A counter/compare match raises interrupt line 5 internally.

A three-state sequencer decides when the core must leave its instruction stream.
- RUN is normal execution, with EXL = 0.
- VECTOR lasts one cycle. In it, `redirect` is high and `handler_pc` (0x80000180) is the fetch target.
- SERVICE is handler execution, with EXL = 1.

The transitions are:
- RUN→VECTOR on an accepted interrupt or a synchronous exception request.
- RUN→SERVICE when software writes EXL = 1.
- VECTOR→SERVICE always, after one cycle.
- SERVICE→VECTOR on a synchronous exception request.
- SERVICE→RUN on the exception-return strobe, or when software writes EXL = 0.

EXL reads as 1 in VECTOR and in SERVICE. While EXL is 1, interrupts are refused and the saved PC is frozen. On return, the core fetches from `epc_out`.

Top module: `xcp_unit`

## Requirements
- R1: After reset:
  - Status reads 0x00000010 and Cause reads 0.
  - Count reads 0 and Compare reads 0xFFFFFFFF.
  - EPC and BadVAddr read 0, and Config reads CONFIG_VALUE (default 0x00000480).
  - `redirect` is 0.
- R2: Register numbers are BadVAddr 8, Count 9, Compare 11, Status 12, Cause 13, EPC 14 and Config 16.
  - A write to Count, Compare, Status or EPC reads back on the next cycle.
  - Writes to BadVAddr, Cause and Config are ignored.
  - Any other register number reads 0.
- R3: The Status layout is:
  - bits 15:8 are the per-line mask (1 = enabled);
  - bit 4 always reads 1;
  - bit 1 is EXL;
  - bit 0 is the global enable;
  - all other bits read 0.
- R4: Cause bits 15:8 show the request lines as sampled at the previous clock edge, whatever the mask. Bit 13 is ORed with the timer pending flag.
- R5: An interrupt is accepted when all of the following hold: global enable = 1, EXL = 0, and (Cause[15:8] AND mask) is nonzero.
  - `redirect` goes high at the next clock edge, for exactly one cycle.
  - At that same edge, EPC captures `next_pc`, the Cause code field (bits 6:2) becomes 0, and EXL becomes 1.
- R6: While EXL = 1, no interrupt causes a redirect.
- R7: A synchronous exception (`exc_req`) causes a redirect at the next edge. Cause bits 6:2 take `exc_code` and BadVAddr takes `exc_vaddr`. EPC captures `next_pc` only if EXL was 0.
- R8: `epc_out` always equals EPC.
  - `eret` in SERVICE returns to RUN, and EXL reads 0 on the next cycle.
  - `exc_req` takes priority over `eret`.
- R9: A software write of Status bit 1 moves between RUN and SERVICE without any redirect.
- R10: Count increases by one at each edge where `tick` is high. A Count write in the same cycle wins over the tick.
- R11: When a tick brings Count equal to Compare, Cause bit 13 becomes 1 one edge later and stays 1. With mask bit 13 and the global enable set, it is accepted like any other line.
- R12: Writing Compare clears the timer pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count advance enable |
| irq_lines | input | 8 | Interrupt request lines, level sensitive |
| next_pc | input | 32 | Address of the instruction about to execute |
| exc_req | input | 1 | Synchronous exception request from the core |
| exc_code | input | 5 | Exception code for `exc_req` |
| exc_vaddr | input | 32 | Faulting address for `exc_req` |
| eret | input | 1 | Exception-return strobe |
| rd_sel | input | 5 | Read register number |
| rd_data | output | 32 | Read data, combinational |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 5 | Write register number |
| wr_data | input | 32 | Write data |
| redirect | output | 1 | Redirect fetch to `handler_pc` this cycle |
| handler_pc | output | 32 | Handler entry address |
| epc_out | output | 32 | Saved exception PC, the return target |

## Verification
The hardest situation to reach is an exception arriving while the unit is already in SERVICE. Only in that case is EPC required to stay frozen while the code field and BadVAddr still change.

The directed sequence gets there in steps:
1. It takes a masked-in interrupt.
2. It lets the one-cycle VECTOR pass.
3. It keeps request lines asserted for several cycles to show that none is accepted.
4. It raises `exc_req` with a new `next_pc`.

A second directed case sets `exc_req` and `eret` together in SERVICE to show which one wins. Random mask and line patterns cover the accept/refuse decision. The timer line is reached by writing Count just below Compare and pulsing `tick`.

// File: rtl/xcp_pkg.sv
package xcp_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_VECTOR  = 2'd1,
        ST_SERVICE = 2'd2
    } seq_state_t;

    localparam logic [4:0] REG_BADVA   = 5'd8;
    localparam logic [4:0] REG_COUNT   = 5'd9;
    localparam logic [4:0] REG_COMPARE = 5'd11;
    localparam logic [4:0] REG_STATUS  = 5'd12;
    localparam logic [4:0] REG_CAUSE   = 5'd13;
    localparam logic [4:0] REG_EPC     = 5'd14;
    localparam logic [4:0] REG_CONFIG  = 5'd16;
endpackage

// File: rtl/xcp_timer.sv
module xcp_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_we,
    input  logic         cmp_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_q,
    output logic [W-1:0] compare_q,
    output logic         pend_q
);
    logic [W-1:0] count_inc;
    assign count_inc = count_q + W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            compare_q <= '1;
            pend_q    <= 1'b0;
        end else begin
            if (cnt_we)
                count_q <= wdata;
            else if (tick)
                count_q <= count_inc;

            if (cmp_we)
                compare_q <= wdata;

            if (cmp_we)
                pend_q <= 1'b0;
            else if (!cnt_we && tick && (count_inc == compare_q))
                pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/xcp_status.sv
module xcp_status #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [N_IRQ-1:0] wmask,
    input  logic             wie,
    input  logic [N_IRQ-1:0] ip,
    output logic [N_IRQ-1:0] mask_q,
    output logic             ie_q,
    output logic             irq_ok
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ie_q   <= 1'b0;
        end else if (we) begin
            mask_q <= wmask;
            ie_q   <= wie;
        end
    end

    assign irq_ok = ie_q & (|(ip & mask_q));
endmodule

// File: rtl/xcp_seq.sv
module xcp_seq
    import xcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_req,
    input  logic       irq_ok,
    input  logic       eret,
    input  logic       exl_we,
    input  logic       exl_wval,
    output seq_state_t state_q,
    output logic       exl,
    output logic       redirect,
    output logic       enter,
    output logic       save_epc
);
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (exc_req || irq_ok)
                    state_d = ST_VECTOR;
                else if (exl_we && exl_wval)
                    state_d = ST_SERVICE;
            end
            ST_VECTOR:
                state_d = ST_SERVICE;
            ST_SERVICE: begin
                if (exc_req)
                    state_d = ST_VECTOR;
                else if (eret)
                    state_d = ST_RUN;
                else if (exl_we && !exl_wval)
                    state_d = ST_RUN;
            end
            default:
                state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        exl      = 1'b0;
        redirect = 1'b0;
        enter    = 1'b0;
        save_epc = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                enter    = exc_req | irq_ok;
                save_epc = exc_req | irq_ok;
            end
            ST_VECTOR: begin
                exl      = 1'b1;
                redirect = 1'b1;
            end
            ST_SERVICE: begin
                exl   = 1'b1;
                enter = exc_req;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xcp_unit.sv
module xcp_unit
    import xcp_pkg::*;
#(
    parameter int          N_IRQ        = 8,
    parameter int          TIMER_LINE   = 5,
    parameter logic [31:0] VECTOR_ADDR  = 32'h8000_0180,
    parameter logic [31:0] CONFIG_VALUE = 32'h0000_0480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [7:0]  irq_lines,
    input  logic [31:0] next_pc,
    input  logic        exc_req,
    input  logic [4:0]  exc_code,
    input  logic [31:0] exc_vaddr,
    input  logic        eret,
    input  logic [4:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic        wr_en,
    input  logic [4:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        redirect,
    output logic [31:0] handler_pc,
    output logic [31:0] epc_out
);
    localparam int IP_LSB   = 8;
    localparam int CODE_LSB = 2;
    localparam int CODE_W   = 5;
    localparam int UM_BIT   = 4;
    localparam int EXL_BIT  = 1;
    localparam int IE_BIT   = 0;

    logic [N_IRQ-1:0]  ip_q;
    logic [N_IRQ-1:0]  mask_q;
    logic              ie_q;
    logic              irq_ok;
    logic [31:0]       count_q;
    logic [31:0]       compare_q;
    logic              tmr_pend;
    logic [31:0]       epc_q;
    logic [31:0]       badva_q;
    logic [CODE_W-1:0] code_q;
    seq_state_t        seq_state;
    logic              exl;
    logic              enter;
    logic              save_epc;
    logic              cnt_we;
    logic              cmp_we;
    logic              st_we;
    logic              epc_we;

    assign cnt_we = wr_en && (wr_sel == REG_COUNT);
    assign cmp_we = wr_en && (wr_sel == REG_COMPARE);
    assign st_we  = wr_en && (wr_sel == REG_STATUS);
    assign epc_we = wr_en && (wr_sel == REG_EPC);

    generate
        for (genvar i = 0; i < N_IRQ; i++) begin : g_line
            if (i == TIMER_LINE) begin : g_tmr
                always_ff @(posedge clk) begin
                    if (!rst_n) ip_q[i] <= 1'b0;
                    else        ip_q[i] <= irq_lines[i] | tmr_pend;
                end
            end else begin : g_ext
                always_ff @(posedge clk) begin
                    if (!rst_n) ip_q[i] <= 1'b0;
                    else        ip_q[i] <= irq_lines[i];
                end
            end
        end
    endgenerate

    xcp_timer #(.W(32)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_we   (cnt_we),
        .cmp_we   (cmp_we),
        .wdata    (wr_data),
        .count_q  (count_q),
        .compare_q(compare_q),
        .pend_q   (tmr_pend)
    );

    xcp_status #(.N_IRQ(N_IRQ)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .wmask (wr_data[IP_LSB +: N_IRQ]),
        .wie   (wr_data[IE_BIT]),
        .ip    (ip_q),
        .mask_q(mask_q),
        .ie_q  (ie_q),
        .irq_ok(irq_ok)
    );

    xcp_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .exc_req (exc_req),
        .irq_ok  (irq_ok),
        .eret    (eret),
        .exl_we  (st_we),
        .exl_wval(wr_data[EXL_BIT]),
        .state_q (seq_state),
        .exl     (exl),
        .redirect(redirect),
        .enter   (enter),
        .save_epc(save_epc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            badva_q <= '0;
            code_q  <= '0;
        end else begin
            if (save_epc)
                epc_q <= next_pc;
            else if (epc_we)
                epc_q <= wr_data;

            if (enter)
                code_q <= exc_req ? exc_code : '0;

            if (enter && exc_req)
                badva_q <= exc_vaddr;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            REG_BADVA:   rd_data = badva_q;
            REG_COUNT:   rd_data = count_q;
            REG_COMPARE: rd_data = compare_q;
            REG_STATUS: begin
                rd_data[IP_LSB +: N_IRQ] = mask_q;
                rd_data[UM_BIT]          = 1'b1;
                rd_data[EXL_BIT]         = exl;
                rd_data[IE_BIT]          = ie_q;
            end
            REG_CAUSE: begin
                rd_data[IP_LSB +: N_IRQ]     = ip_q;
                rd_data[CODE_LSB +: CODE_W]  = code_q;
            end
            REG_EPC:     rd_data = epc_q;
            REG_CONFIG:  rd_data = CONFIG_VALUE;
            default:     rd_data = '0;
        endcase
    end

    assign handler_pc = VECTOR_ADDR;
    assign epc_out    = epc_q;
endmodule

// File: rtl/xcp_checker.sv
module xcp_checker
    import xcp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        redirect,
    input logic        exc_req,
    input logic        eret,
    input logic        tick,
    input logic        wr_en,
    input logic [4:0]  wr_sel,
    input seq_state_t  state_q,
    input logic        exl,
    input logic        enter,
    input logic [31:0] epc_q,
    input logic [4:0]  code_q,
    input logic [31:0] count_q,
    input logic        cnt_we,
    input logic        cmp_we,
    input logic        tmr_pend
);
    // R5: a redirect lasts exactly one cycle
    assert_one_cycle_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R5: interrupt entry leaves code 0
    assert_irq_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !exc_req) |=> (code_q == 5'd0));

    // R6: no interrupt entry while EXL is set
    assert_exl_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exl && !exc_req) |=> !redirect);

    // R7: EPC frozen while EXL is set unless software writes it
    assert_epc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exl && !(wr_en && wr_sel == REG_EPC)) |=> $stable(epc_q));

    // R8: return from the handler clears EXL
    assert_eret_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && eret && !exc_req) |=> !exl);

    // R10: count advances by one on a tick
    assert_tick_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we) |=> (count_q == $past(count_q) + 32'd1));

    // R12: compare write clears the timer flag
    assert_cmp_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !tmr_pend);
endmodule

bind xcp_unit xcp_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .redirect(redirect),
    .exc_req (exc_req),
    .eret    (eret),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .state_q (seq_state),
    .exl     (exl),
    .enter   (enter),
    .epc_q   (epc_q),
    .code_q  (code_q),
    .count_q (count_q),
    .cnt_we  (cnt_we),
    .cmp_we  (cmp_we),
    .tmr_pend(tmr_pend)
);

// File: tb/xcp_unit_test.sv
module xcp_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  irq_lines = '0;
    logic [31:0] next_pc = '0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_vaddr = '0;
    logic        eret = 1'b0;
    logic [4:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        redirect;
    logic [31:0] handler_pc;
    logic [31:0] epc_out;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [4:0] A_BADVA = 5'd8, A_COUNT = 5'd9, A_CMP = 5'd11,
                           A_STAT = 5'd12, A_CAUSE = 5'd13, A_EPC = 5'd14, A_CFG = 5'd16;

    always #2 clk = ~clk;

    xcp_unit uut (.*);

    function automatic logic [31:0] exp_status(logic [7:0] m, logic x, logic ie);
        return {16'h0, m, 3'b000, 1'b1, 2'b00, x, ie};
    endfunction

    function automatic logic exp_take(logic [7:0] ln, logic [7:0] m);
        return |(ln & m);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [4:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(logic [4:0] sel, logic [31:0] v);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pc_a;
        logic [31:0] bva;
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset values
        rd(A_STAT, v);  chk("R1 status", v, 32'h10);
        rd(A_CAUSE, v); chk("R1 cause", v, 0);
        rd(A_COUNT, v); chk("R1 count", v, 0);
        rd(A_CMP, v);   chk("R1 compare", v, 32'hFFFF_FFFF);
        rd(A_EPC, v);   chk("R1 epc", v, 0);
        rd(A_BADVA, v); chk("R1 badva", v, 0);
        rd(A_CFG, v);   chk("R1 config", v, 32'h480);
        chk("R1 redirect", {31'h0, redirect}, 0);

        // R4/R5 random masks and lines
        for (int it = 0; it < 40; it++) begin
            logic [7:0] m;
            logic [7:0] ln;
            logic [31:0] pc;
            logic t;
            m  = 8'($urandom);
            ln = 8'($urandom);
            if (it == 0) ln = 8'h00;
            if (it == 1) begin m = 8'hFF; ln = 8'h80; end
            pc = $urandom & 32'hFFFF_FFFC;
            t  = exp_take(ln, m);
            wr(A_STAT, {16'h0, m, 8'h00});
            irq_lines = ln; next_pc = pc;
            step(2);
            rd(A_CAUSE, v); chk("R4 raw pending", {24'h0, v[15:8]}, {24'h0, ln});
            wr(A_STAT, {16'h0, m, 8'h01});
            chk("R5 no early redirect", {31'h0, redirect}, 0);
            step(1);
            chk("R5 accept decision", {31'h0, redirect}, {31'h0, t});
            if (t) begin
                rd(A_EPC, v);   chk("R5 epc saved", v, pc);
                rd(A_STAT, v);  chk("R5 exl set", v, exp_status(m, 1'b1, 1'b1));
                rd(A_CAUSE, v); chk("R5 code zero", {27'h0, v[6:2]}, 0);
                chk("R5 handler pc", handler_pc, 32'h8000_0180);
                step(1);
                chk("R5 single cycle", {31'h0, redirect}, 0);
                irq_lines = 8'h00; eret = 1'b1;
                step(1);
                eret = 1'b0;
                rd(A_STAT, v); chk("R8 eret clears exl", v, exp_status(m, 1'b0, 1'b1));
                chk("R8 epc_out", epc_out, pc);
            end else begin
                irq_lines = 8'h00;
                step(1);
            end
        end
        wr(A_STAT, 32'h0);
        step(1);

        // R6/R7 exception while in handler
        pc_a = 32'h0000_4000;
        wr(A_STAT, 32'h0000_0101);
        irq_lines = 8'h01; next_pc = pc_a;
        step(2);
        chk("R5 directed take", {31'h0, redirect}, 1);
        step(1);
        irq_lines = 8'h03;
        for (int k = 0; k < 4; k++) begin
            step(1);
            chk("R6 blocked while exl", {31'h0, redirect}, 0);
        end
        exc_req = 1'b1; exc_code = 5'd4; exc_vaddr = 32'hDEAD_0004; next_pc = 32'h0000_5000;
        step(1);
        exc_req = 1'b0;
        chk("R7 exc redirect", {31'h0, redirect}, 1);
        rd(A_EPC, v);   chk("R7 epc frozen", v, pc_a);
        rd(A_CAUSE, v); chk("R7 code", {27'h0, v[6:2]}, 4);
        rd(A_BADVA, v); chk("R7 badva", v, 32'hDEAD_0004);
        step(1);
        irq_lines = 8'h00; eret = 1'b1;
        step(1);
        eret = 1'b0;
        rd(A_STAT, v); chk("R8 exl cleared", v, exp_status(8'h01, 1'b0, 1'b1));

        // R7 exception from RUN saves EPC
        exc_req = 1'b1; exc_code = 5'd10; exc_vaddr = 32'h0000_0BAD; next_pc = 32'h0000_6000;
        step(1);
        exc_req = 1'b0;
        chk("R7 run redirect", {31'h0, redirect}, 1);
        rd(A_EPC, v);   chk("R7 epc from run", v, 32'h0000_6000);
        rd(A_CAUSE, v); chk("R7 code run", {27'h0, v[6:2]}, 10);
        step(1);
        // R8 priority of exception over return
        exc_req = 1'b1; eret = 1'b1; exc_code = 5'd12; exc_vaddr = 32'h0000_0C00;
        step(1);
        exc_req = 1'b0; eret = 1'b0;
        chk("R8 exc beats eret", {31'h0, redirect}, 1);
        rd(A_STAT, v); chk("R8 still exl", {31'h0, v[1]}, 1);
        bva = 32'h0000_0C00;
        step(1);
        eret = 1'b1; step(1); eret = 1'b0;
        wr(A_STAT, 32'h0);

        // R9 software EXL
        wr(A_STAT, 32'h0000_0002);
        chk("R9 no redirect on sw set", {31'h0, redirect}, 0);
        rd(A_STAT, v); chk("R9 sw exl set", v, 32'h12);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R9 sw exl clear", v, 32'h10);

        // R2/R3 register access
        wr(A_COUNT, 32'h1234);      rd(A_COUNT, v); chk("R2 count rw", v, 32'h1234);
        wr(A_CMP, 32'h4000);        rd(A_CMP, v);   chk("R2 compare rw", v, 32'h4000);
        wr(A_EPC, 32'hCAFE_0000);   rd(A_EPC, v);   chk("R2 epc rw", v, 32'hCAFE_0000);
        chk("R8 epc_out follows", epc_out, 32'hCAFE_0000);
        wr(A_BADVA, 32'hFFFF);      rd(A_BADVA, v); chk("R2 badva ignores write", v, bva);
        wr(A_CFG, 32'hFFFF);        rd(A_CFG, v);   chk("R2 config ignores write", v, 32'h480);
        wr(A_CAUSE, 32'hFFFF_FFFF); step(1);
        rd(A_CAUSE, v); chk("R2 cause ignores write", v, {25'h0, 5'd12, 2'b00});
        wr(5'd3, 32'hFFFF_FFFF);    rd(5'd3, v);    chk("R2 unmapped reads 0", v, 0);
        wr(A_STAT, 32'hFFFF_FFFD);  rd(A_STAT, v);  chk("R3 status layout", v, 32'h0000_FF11);
        wr(A_STAT, 32'h0);

        // R10 tick and write priority
        wr(A_COUNT, 32'h2);
        wr(A_CMP, 32'h5);
        tick = 1'b1;
        step(3);
        tick = 1'b0;
        rd(A_COUNT, v); chk("R10 three ticks", v, 32'h5);
        rd(A_CAUSE, v); chk("R11 not yet pending", {31'h0, v[13]}, 0);
        step(1);
        rd(A_CAUSE, v); chk("R11 timer pending", {31'h0, v[13]}, 1);
        step(3);
        rd(A_CAUSE, v); chk("R11 pending holds", {31'h0, v[13]}, 1);
        wr(A_STAT, 32'h0000_2001);
        step(1);
        chk("R11 timer accepted", {31'h0, redirect}, 1);
        step(1);
        wr(A_CMP, 32'd100);
        step(1);
        rd(A_CAUSE, v); chk("R12 compare write clears", {31'h0, v[13]}, 0);
        eret = 1'b1; step(1); eret = 1'b0;
        wr(A_STAT, 32'h0);
        tick = 1'b1;
        wr(A_COUNT, 32'h50);
        tick = 1'b0;
        rd(A_COUNT, v); chk("R10 write beats tick", v, 32'h50);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
        $finish;
    end
endmodule